// File: doc/BRIEF.md
# Bi-phase infrared command frame transmitter

This block turns a key event into one 14-bit infrared command frame. It drives a single LED line.

A one-cycle send strobe captures a 5-bit device address, a 7-bit command and a flag that marks a fresh key press. The block then plays the frame out bit by bit. Each bit is split into two equal half-bits. In a mark half the line carries a gated carrier; in a space half the line stays low.

A persistent toggle bit lets the receiver tell a held key apart from a second press of the same key. The seventh command bit is folded into the second start bit, in inverted form. This extends the command range to 128 codes.

One clock divider sets both periods. The carrier period is a parameter counted in system clocks. The half-bit length is a parameter counted in carrier periods. While a frame is on the line the block raises a busy flag. When the last half-bit ends it gives a one-cycle done pulse. Key scanning and the spacing between repeated frames belong to the logic that drives the strobe.

Top module: `ir_frame_tx`

## Requirements
- R1: The frame is 14 bits, sent in this order: a start bit that is always 1, the field bit, the toggle bit, address bits 4 down to 0, and command bits 5 down to 0. Both fields are sent most significant bit first.
- R2: Every half-bit lasts exactly CAR_PERIOD*HALF_CARRIERS clocks, and a frame lasts 28 half-bits.
- R3: A 1 bit is a space half followed by a mark half. A 0 bit is a mark half followed by a space half.
- R4: During a mark half, led_o is high for the first CAR_HIGH clocks of every CAR_PERIOD-clock carrier period, and low otherwise. During a space half, led_o stays low.
- R5: The toggle bit is 0 after reset. An accepted strobe with new_key_i=1 inverts it, and that frame carries the new value. An accepted strobe with new_key_i=0 sends the held value unchanged.
- R6: The second frame bit equals the inverse of cmd_i[6]. So it is 1 for commands 0 to 63 and 0 for commands 64 to 127.
- R7: busy_o rises in the cycle after an accepted strobe and stays high for the whole frame. A strobe that arrives while busy_o is high changes neither the frame on the line nor the toggle bit.
- R8: done_o is high for exactly one cycle: the first cycle after the last half-bit, in which busy_o is low again.
- R9: During and after reset, led_o, busy_o and done_o are low. led_o stays low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_i | input | 1 | One-cycle request to send a frame |
| addr_i | input | 5 | Device address |
| cmd_i | input | 7 | Command code, 0 to 127 |
| new_key_i | input | 1 | High when the request comes from a fresh key press |
| led_o | output | 1 | Carrier-gated LED drive |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The bench builds the block with a 4-clock carrier period, a 1-clock carrier high time and 3 carrier periods per half-bit. A whole frame then takes 336 clocks, so all 128 command codes fit in one run, each paired with a different address and a varied new-key pattern. This covers every field bit value and every address bit position.

The LED line is compared with the expected waveform clock by clock. It is also decoded back into bits to check the field order. Some frames receive a stray strobe in mid-flight, carrying a different address and a new-key flag. Those frames show that the strobe is ignored by both the line and the toggle bit.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int FRAME_BITS = 14;
  localparam int HALVES     = 2 * FRAME_BITS;
  localparam int ADDR_W     = 5;
  localparam int CMD_W      = 7;

  typedef logic [FRAME_BITS-1:0] frame_t;

  // MSB is sent first
  function automatic frame_t build_frame(input logic [ADDR_W-1:0] addr,
                                         input logic [CMD_W-1:0]  cmd,
                                         input logic              tog);
    return {1'b1, ~cmd[CMD_W-1], tog, addr, cmd[CMD_W-2:0]};
  endfunction
endpackage

// File: rtl/ir_tx_timebase.sv
module ir_tx_timebase #(
  parameter int CAR_PERIOD    = 100,
  parameter int CAR_HIGH      = 30,
  parameter int HALF_CARRIERS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic carrier_o,
  output logic half_end_o
);
  localparam int CW = (CAR_PERIOD > 1) ? $clog2(CAR_PERIOD) : 1;
  localparam int NW = (HALF_CARRIERS > 1) ? $clog2(HALF_CARRIERS) : 1;
  localparam logic [CW-1:0] CAR_LAST = CW'(CAR_PERIOD - 1);
  localparam logic [CW-1:0] CAR_HI   = CW'(CAR_HIGH);
  localparam logic [NW-1:0] NUM_LAST = NW'(HALF_CARRIERS - 1);

  logic [CW-1:0] car_cnt;
  logic [NW-1:0] car_num;
  logic          car_wrap;

  assign car_wrap   = (car_cnt == CAR_LAST);
  assign half_end_o = run_i && car_wrap && (car_num == NUM_LAST);
  assign carrier_o  = (car_cnt < CAR_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_cnt <= '0;
      car_num <= '0;
    end else if (!run_i) begin
      car_cnt <= '0;
      car_num <= '0;
    end else if (car_wrap) begin
      car_cnt <= '0;
      car_num <= (car_num == NUM_LAST) ? '0 : car_num + 1'b1;
    end else begin
      car_cnt <= car_cnt + 1'b1;
    end
  end

  assert_car_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_cnt <= CAR_LAST);
  assert_idle_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (car_cnt == '0 && car_num == '0));
endmodule

// File: rtl/ir_tx_toggle.sv
module ir_tx_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic new_key_i,
  output logic toggle_o
);
  logic tog_q;

  // value carried by the frame being accepted
  assign toggle_o = tog_q ^ (accept_i & new_key_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tog_q <= 1'b0;
    else if (accept_i && new_key_i) tog_q <= ~tog_q;
  end

  assert_toggle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_i && new_key_i) |=> $stable(tog_q));
  assert_toggle_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && new_key_i) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/ir_tx_sequencer.sv
module ir_tx_sequencer
  import ir_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_i,
  input  frame_t frame_i,
  input  logic   half_end_i,
  output logic   busy_o,
  output logic   done_o,
  output logic   mark_o
);
  localparam int HW = $clog2(HALVES);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALVES - 1);

  frame_t        shift_q;
  logic [HW-1:0] half_idx;
  logic          busy_q;
  logic          done_q;

  // 1 = space then mark, 0 = mark then space
  assign mark_o = ~(shift_q[FRAME_BITS-1] ^ half_idx[0]);
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      half_idx <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_i) begin
        shift_q  <= frame_i;
        half_idx <= '0;
        busy_q   <= 1'b1;
      end else if (busy_q && half_end_i) begin
        if (half_idx == HALF_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          half_idx <= half_idx + 1'b1;
          if (half_idx[0]) shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assert_frame_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !half_end_i) |=> $stable(shift_q) && $stable(half_idx));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_half_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_idx <= HALF_LAST);
endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
  import ir_tx_pkg::*;
#(
  parameter int CAR_PERIOD    = 100,
  parameter int CAR_HIGH      = 30,
  parameter int HALF_CARRIERS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  send_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CMD_W-1:0]      cmd_i,
  input  logic                  new_key_i,
  output logic                  led_o,
  output logic                  busy_o,
  output logic                  done_o
);
  logic   accept, toggle, carrier, half_end, mark, busy;
  frame_t frame;

  assign accept = send_i & ~busy;
  assign frame  = build_frame(addr_i, cmd_i, toggle);

  ir_tx_toggle u_toggle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .new_key_i (new_key_i),
    .toggle_o  (toggle)
  );

  ir_tx_timebase #(
    .CAR_PERIOD    (CAR_PERIOD),
    .CAR_HIGH      (CAR_HIGH),
    .HALF_CARRIERS (HALF_CARRIERS)
  ) u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy),
    .carrier_o  (carrier),
    .half_end_o (half_end)
  );

  ir_tx_sequencer u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .frame_i    (frame),
    .half_end_i (half_end),
    .busy_o     (busy),
    .done_o     (done_o),
    .mark_o     (mark)
  );

  assign busy_o = busy;
  assign led_o  = busy & mark & carrier;

  assert_led_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o |-> busy_o);
  assert_busy_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !busy_o) |=> busy_o);
  assert_done_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o));
endmodule

// File: tb/tb_ir_frame_tx.sv
module tb_ir_frame_tx;
  localparam int P  = 4;
  localparam int H  = 1;
  localparam int N  = 3;
  localparam int HL = P * N;
  localparam int FL = 28 * HL;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       send_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [6:0] cmd_i = '0;
  logic       new_key_i = 1'b0;
  logic       led_o, busy_o, done_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic tb_tog = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ir_frame_tx #(.CAR_PERIOD(P), .CAR_HIGH(H), .HALF_CARRIERS(N)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .send_i(send_i), .addr_i(addr_i),
    .cmd_i(cmd_i), .new_key_i(new_key_i), .led_o(led_o), .busy_o(busy_o),
    .done_o(done_o)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [4:0] a, input logic [6:0] c,
                            input logic nk, input bit stray);
    logic bits [14];
    logic mk [28];
    int   wave_err, busy_err, code_err;
    int   got_addr, got_cmd;
    logic got_b1, got_b2, got_b3;
    @(negedge clk_i);
    if (nk) tb_tog = ~tb_tog;
    bits[0] = 1'b1;
    bits[1] = ~c[6];
    bits[2] = tb_tog;
    for (int k = 0; k < 5; k++) bits[3+k] = a[4-k];
    for (int k = 0; k < 6; k++) bits[8+k] = c[5-k];
    send_i = 1'b1; addr_i = a; cmd_i = c; new_key_i = nk;
    @(negedge clk_i);
    send_i = 1'b0;
    wave_err = 0; busy_err = 0; code_err = 0;
    for (int h = 0; h < 28; h++) mk[h] = 1'b0;
    for (int i = 0; i < FL; i++) begin
      int  h;
      logic exp_mark, exp_led;
      h = i / HL;
      exp_mark = (h % 2 == 0) ? ~bits[h/2] : bits[h/2];
      exp_led  = exp_mark && ((i % P) < H);
      if (led_o !== exp_led) wave_err++;
      if (busy_o !== 1'b1 || done_o !== 1'b0) busy_err++;
      if (led_o === 1'b1) mk[h] = 1'b1;
      if (stray && (i == 5 * HL + 2)) begin
        send_i = 1'b1; addr_i = ~a; cmd_i = ~c; new_key_i = 1'b1;
      end else begin
        send_i = 1'b0;
      end
      @(negedge clk_i);
    end
    send_i = 1'b0;
    check(wave_err == 0, "R4 carrier waveform", wave_err, 0);
    check(busy_err == 0, "R2/R7 busy for whole frame", busy_err, 0);
    check(busy_o === 1'b0 && done_o === 1'b1, "R8 done at frame end",
          {busy_o, done_o}, 1);
    for (int j = 0; j < 14; j++)
      if (mk[2*j] === mk[2*j+1] || mk[2*j+1] !== bits[j]) code_err++;
    check(code_err == 0, "R3 bi-phase coding", code_err, 0);
    got_b1 = mk[1]; got_b2 = mk[3]; got_b3 = mk[5];
    got_addr = 0; got_cmd = 0;
    for (int k = 0; k < 5; k++) got_addr = got_addr * 2 + int'(mk[2*(3+k)+1]);
    for (int k = 0; k < 6; k++) got_cmd = got_cmd * 2 + int'(mk[2*(8+k)+1]);
    check(got_b1 === 1'b1, "R1 start bit", got_b1, 1);
    check(got_b2 === ~c[6], "R6 field bit", got_b2, ~c[6]);
    check(got_b3 === tb_tog, "R5 toggle bit", got_b3, tb_tog);
    check(got_addr == int'(a), "R1 address MSB first", got_addr, a);
    check(got_cmd == int'(c[5:0]), "R1 command MSB first", got_cmd, c[5:0]);
    @(negedge clk_i);
    check(done_o === 1'b0 && led_o === 1'b0, "R8/R9 single done, idle line",
          {done_o, led_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(led_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R9 outputs in reset", {led_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(led_o === 1'b0 && busy_o === 1'b0, "R9 idle after reset",
          {led_o, busy_o}, 0);
    // toggle kept at reset value 0 when first strobe is a repeat
    send_frame(5'h05, 7'h35, 1'b0, 1'b0);
    for (int c = 0; c < 128; c++) begin
      send_frame(5'((c * 7 + 3) % 32), 7'(c), (c % 3) != 0, (c % 16) == 5);
      if (c % 32 == 0) begin
        repeat (5) @(negedge clk_i);
        check(led_o === 1'b0 && busy_o === 1'b0, "R9 line low between frames",
              {led_o, busy_o}, 0);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule